// File: doc/BRIEF.md
# Low-Voltage Reset Filter Controller

This block is the digital half of a supply supervisor. Two analog comparators feed it. One is high while the supply sits under the chosen trip level. The other is high while the supply is above that level plus a hysteresis margin. Both inputs are first brought into the sampling clock domain through a synchronizer chain. The low-supply indication then passes through a run-length filter. A low-voltage reset is raised only when the supply has been low for an unbroken run of sampling edges. Short dips are not enough.

Once raised, the reset holds until the upper comparator reports that the supply has cleared the hysteresis threshold. Simply leaving the low region does not release it. The block has separate enables for monitoring and for reset generation. It also has a raw status flag that skips the filter, a pass-through select that picks one of two comparator trip levels, and an active-high drive for pulling the external reset pin low. A power-on reset input starts everything from a known state with reset asserted.

Top module: `lvr_filter_ctrl`

## Requirements
- R1: While `mon_en_i` is 0 and `por_n_i` is 1, `lvr_rst_n_o` is 1 and `status_o` is 0.
- R2: While `rst_en_i` is 0 and monitoring is on, `status_o` still follows the low-supply input, but `lvr_rst_n_o` stays 1.
- R3: The low-supply input may be raised just before clock edge k and held there, with both enables at 1 and no reset active. Then `lvr_rst_n_o` is still 1 after edge k+10 and is 0 after edge k+11. This is two synchronizer stages, a run of RUN_LEN = 9 samples, and one register.
- R4: A sample that is not low-supply clears the run. A run of 8 or fewer consecutive low samples never raises the reset, and a run of 9 or more always does.
- R5: Once the reset is asserted, it stays asserted while the hysteresis input is 0, even after the low-supply input has returned to 0.
- R6: The hysteresis input may be raised just before edge j while the reset is asserted and the low-supply input is 0. Then `lvr_rst_n_o` is still 0 after edge j+1 and is 1 after edge j+2.
- R7: `status_o` follows the synchronized low-supply input with no run filter. An input raised before edge k gives `status_o` = 0 after edge k and 1 after edge k+1.
- R8: `trip_sel_o` always equals `trip_sel_i`. A value of 0 selects the lower trip level and 1 selects the upper.
- R9: `pin_pull_o` is 1 exactly when `lvr_rst_n_o` is 0.
- R10: The run counter saturates at RUN_LEN and does not wrap. After a long low run with reset generation disabled, setting `rst_en_i` to 1 while the input is still low asserts the reset after the next edge.
- R11: While `por_n_i` is 0, `lvr_rst_n_o` is 0. After power-on reset is released with both enables at 1, the reset stays asserted until the hysteresis release of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| por_n_i | input | 1 | Active-low power-on reset, asynchronous |
| cmp_low_i | input | 1 | Comparator: supply below trip level |
| cmp_hys_i | input | 1 | Comparator: supply above trip level plus hysteresis |
| mon_en_i | input | 1 | Monitoring enable |
| rst_en_i | input | 1 | Reset generation enable |
| trip_sel_i | input | 1 | Trip level choice (0 low, 1 high) |
| trip_sel_o | output | 1 | Trip level select to the comparator |
| status_o | output | 1 | Unfiltered low-supply status flag |
| lvr_rst_n_o | output | 1 | Active-low low-voltage reset |
| pin_pull_o | output | 1 | Drives the external reset pin low when 1 |

## Verification
The bench sweeps the length of the low-supply run from 0 to 14 samples and checks the 8/9 boundary. A filter that is off by one, or that fails to clear on a gap, would trip at the wrong length. It measures the exact edges of assertion and release, which exposes a missing or extra synchronizer stage or register. It drops the low input while the hysteresis input stays low to catch a design that releases on the wrong comparator. It also holds a run long enough to wrap an unsaturated 4-bit counter, which would leave the reset unasserted one edge after reset generation is re-enabled.

// File: rtl/lvr_pkg.sv
package lvr_pkg;
   typedef enum logic [0:0] {
      LVR_IDLE = 1'b0,
      LVR_HOLD = 1'b1
   } lvr_state_t;

   function automatic int unsigned lvr_cnt_width(input int unsigned run_len);
      return (run_len < 2) ? 1 : $clog2(run_len + 1);
   endfunction
endpackage

// File: rtl/lvr_sync.sv
module lvr_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 2
) (
   input  logic             clk,
   input  logic             por_n_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lvr_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge por_n_i) begin
               if (!por_n_i) stage_q[0] <= '0;
               else          stage_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge por_n_i) begin
               if (!por_n_i) stage_q[s] <= '0;
               else          stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/lvr_run_filter.sv
module lvr_run_filter #(
   parameter int unsigned RUN_LEN = 9,
   parameter int unsigned CNT_W   = 4
) (
   input  logic             clk,
   input  logic             por_n_i,
   input  logic             en_i,
   input  logic             low_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             hit_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

   generate
      if (RUN_LEN < 1) begin : g_bad_len
         $error("lvr_run_filter: RUN_LEN must be at least 1");
      end
      if ((2 ** CNT_W) <= RUN_LEN) begin : g_bad_width
         $error("lvr_run_filter: CNT_W too narrow for RUN_LEN");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge por_n_i) begin
      if (!por_n_i) begin
         cnt_q <= '0;
      end else if (!en_i || !low_i) begin
         cnt_q <= '0;
      end else if (cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;
   assign hit_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/lvr_reset_ctrl.sv
module lvr_reset_ctrl
   import lvr_pkg::*;
(
   input  logic clk,
   input  logic por_n_i,
   input  logic mon_en_i,
   input  logic rst_en_i,
   input  logic hit_i,
   input  logic hys_i,
   output logic hold_o
);
   lvr_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (!mon_en_i || !rst_en_i) begin
         state_d = LVR_IDLE;
      end else begin
         unique case (state_q)
            LVR_IDLE: if (hit_i) state_d = LVR_HOLD;
            LVR_HOLD: if (hys_i) state_d = LVR_IDLE;
            default:  state_d = LVR_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge por_n_i) begin
      if (!por_n_i) state_q <= LVR_HOLD;
      else          state_q <= state_d;
   end

   assign hold_o = (state_q == LVR_HOLD);
endmodule

// File: rtl/lvr_filter_ctrl.sv
module lvr_filter_ctrl
   import lvr_pkg::*;
#(
   parameter int unsigned RUN_LEN     = 9,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic por_n_i,
   input  logic cmp_low_i,
   input  logic cmp_hys_i,
   input  logic mon_en_i,
   input  logic rst_en_i,
   input  logic trip_sel_i,
   output logic trip_sel_o,
   output logic status_o,
   output logic lvr_rst_n_o,
   output logic pin_pull_o
);
   localparam int unsigned CNT_W = lvr_cnt_width(RUN_LEN);

   logic [1:0]       cmp_raw, cmp_s;
   logic             low_s, hys_s;
   logic [CNT_W-1:0] run_cnt;
   logic             run_hit;
   logic             hold;
   logic             rst_act;

   assign cmp_raw = {cmp_hys_i, cmp_low_i};

   lvr_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk     (clk),
      .por_n_i (por_n_i),
      .d_i     (cmp_raw),
      .q_o     (cmp_s)
   );

   assign low_s = cmp_s[0];
   assign hys_s = cmp_s[1];

   lvr_run_filter #(.RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) u_filt (
      .clk     (clk),
      .por_n_i (por_n_i),
      .en_i    (mon_en_i),
      .low_i   (low_s),
      .cnt_o   (run_cnt),
      .hit_o   (run_hit)
   );

   lvr_reset_ctrl u_rctl (
      .clk      (clk),
      .por_n_i  (por_n_i),
      .mon_en_i (mon_en_i),
      .rst_en_i (rst_en_i),
      .hit_i    (run_hit),
      .hys_i    (hys_s),
      .hold_o   (hold)
   );

   assign rst_act     = !por_n_i || (hold && mon_en_i && rst_en_i);
   assign lvr_rst_n_o = !rst_act;
   assign pin_pull_o  = rst_act;
   assign status_o    = mon_en_i && low_s;
   assign trip_sel_o  = trip_sel_i;
endmodule

// File: rtl/lvr_filter_chk.sv
module lvr_filter_chk #(
   parameter int unsigned RUN_LEN = 9,
   parameter int unsigned CNT_W   = 4
) (
   input logic             clk,
   input logic             por_n_i,
   input logic             mon_en_i,
   input logic             rst_en_i,
   input logic             status_o,
   input logic             lvr_rst_n_o,
   input logic             low_s,
   input logic             hys_s,
   input logic             hold,
   input logic [CNT_W-1:0] run_cnt
);
   // R1: monitoring off means no reset and no status
   assert_mon_off_quiet_R1: assert property (@(posedge clk) disable iff (!por_n_i)
      !mon_en_i |-> (lvr_rst_n_o && !status_o));

   // R3: the hold state is entered only after a full run
   assert_trip_needs_run_R3: assert property (@(posedge clk) disable iff (!por_n_i)
      $rose(hold) |-> ($past(run_cnt) == CNT_W'(RUN_LEN)));

   // R4: a sample that is not low clears the run
   assert_gap_clears_R4: assert property (@(posedge clk) disable iff (!por_n_i)
      !low_s |=> (run_cnt == '0));

   // R5 and R6: release only with the hysteresis input while enabled
   assert_release_hys_R5: assert property (@(posedge clk) disable iff (!por_n_i)
      ($fell(hold) && $past(mon_en_i) && $past(rst_en_i)) |-> $past(hys_s));

   // R10: counter never exceeds its limit
   assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!por_n_i)
      run_cnt <= CNT_W'(RUN_LEN));
endmodule

bind lvr_filter_ctrl lvr_filter_chk #(.RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .por_n_i     (por_n_i),
   .mon_en_i    (mon_en_i),
   .rst_en_i    (rst_en_i),
   .status_o    (status_o),
   .lvr_rst_n_o (lvr_rst_n_o),
   .low_s       (low_s),
   .hys_s       (hys_s),
   .hold        (hold),
   .run_cnt     (run_cnt)
);

// File: tb/sim_lvr_filter_ctrl.sv
module sim_lvr_filter_ctrl;
   localparam time CLK_PERIOD = 10ns;
   localparam int  RUN = 9;

   logic clk = 1'b0;
   logic por_n, cmp_low, cmp_hys, mon_en, rst_en, trip_sel;
   logic trip_sel_o, status_o, lvr_rst_n_o, pin_pull_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lvr_filter_ctrl #(.RUN_LEN(RUN), .SYNC_STAGES(2)) u0 (
      .clk(clk), .por_n_i(por_n), .cmp_low_i(cmp_low), .cmp_hys_i(cmp_hys),
      .mon_en_i(mon_en), .rst_en_i(rst_en), .trip_sel_i(trip_sel),
      .trip_sel_o(trip_sel_o), .status_o(status_o),
      .lvr_rst_n_o(lvr_rst_n_o), .pin_pull_o(pin_pull_o)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // wait n rising edges, then settle at the following falling edge
   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic release_rst();
      cmp_low = 1'b0;
      cmp_hys = 1'b1;
      edges(4);
      cmp_hys = 1'b0;
      edges(4);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      por_n = 1'b0; cmp_low = 1'b0; cmp_hys = 1'b0;
      mon_en = 1'b1; rst_en = 1'b1; trip_sel = 1'b0;
      edges(3);
      // R11: reset held during power-on reset
      check("R11 por asserts", lvr_rst_n_o, 1'b0);
      check("R9 pin pull during por", pin_pull_o, 1'b1);
      por_n = 1'b1;
      edges(6);
      check("R11 held after por without hys", lvr_rst_n_o, 1'b0);
      // R6: release timing
      cmp_hys = 1'b1;
      edges(2);
      check("R6 still low after j+1", lvr_rst_n_o, 1'b0);
      edges(1);
      check("R6 released after j+2", lvr_rst_n_o, 1'b1);
      check("R9 pin pull released", pin_pull_o, 1'b0);
      cmp_hys = 1'b0;
      edges(4);

      // R8: trip select pass-through
      for (int t = 0; t < 2; t++) begin
         trip_sel = t[0];
         #1;
         check("R8 trip select", trip_sel_o, t[0]);
      end

      // R7: status timing
      cmp_low = 1'b1;
      edges(1);
      check("R7 status low after k", status_o, 1'b0);
      edges(1);
      check("R7 status high after k+1", status_o, 1'b1);
      cmp_low = 1'b0;
      edges(4);
      check("R7 status follows drop", status_o, 1'b0);

      // R3: exact assertion edge
      cmp_low = 1'b1;
      edges(11);
      check("R3 high after k+10", lvr_rst_n_o, 1'b1);
      edges(1);
      check("R3 low after k+11", lvr_rst_n_o, 1'b0);
      check("R9 pin pull in reset", pin_pull_o, 1'b1);
      // R5: leaving low region does not release
      cmp_low = 1'b0;
      edges(30);
      check("R5 held without hys", lvr_rst_n_o, 1'b0);
      release_rst();
      check("R5 released by hys", lvr_rst_n_o, 1'b1);

      // R4: run-length sweep
      for (int n = 0; n <= 14; n++) begin
         cmp_low = 1'b1;
         repeat (n) @(posedge clk);
         @(negedge clk);
         cmp_low = 1'b0;
         edges(15);
         check($sformatf("R4 run of %0d", n), lvr_rst_n_o, (n >= RUN) ? 1'b0 : 1'b1);
         release_rst();
      end
      // R4: a one-sample gap splits two sub-threshold runs
      cmp_low = 1'b1; edges(7);
      cmp_low = 1'b0; edges(0);
      cmp_low = 1'b1; edges(7);
      cmp_low = 1'b0; edges(15);
      check("R4 gap clears run", lvr_rst_n_o, 1'b1);

      // R2: reset generation disabled
      rst_en = 1'b0;
      cmp_low = 1'b1;
      edges(40);
      check("R2 status still updates", status_o, 1'b1);
      check("R2 no reset", lvr_rst_n_o, 1'b1);
      // R10: saturated counter trips right after enabling
      rst_en = 1'b1;
      edges(1);
      check("R10 saturated trip next edge", lvr_rst_n_o, 1'b0);
      release_rst();

      // R1: monitoring off
      mon_en = 1'b0;
      cmp_low = 1'b1;
      edges(30);
      check("R1 no status", status_o, 1'b0);
      check("R1 no reset", lvr_rst_n_o, 1'b1);
      cmp_low = 1'b0;
      edges(3);
      mon_en = 1'b1;
      edges(3);
      check("R1 no latent reset after enable", lvr_rst_n_o, 1'b1);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule